// File: doc/BRIEF.md
# Cell-Level Multi-PHY Transmit Master

This block is the ATM-layer transmit end of a shared multi-PHY cell bus. It owns the bus clock domain and drives the 5-bit PHY address, the active-low transmit enable, the start-of-cell flag and the 8-bit data lane. Up to four PHY addresses sit in a small table given by `slot_addr`, and each entry has an enable bit. While idle, the block polls the enabled entries in round-robin order, one address per clock. Each PHY answers on the shared cell-available line one clock after it sees its address.

Cells come from an internal byte-wide source. The first byte of a cell carries a slot tag, `src_dest`, that names the target table entry. The source stalls, with `src_ready` low, until that entry's PHY has most recently reported room for a whole cell. The block then selects the PHY: for one clock it drives the PHY's address with enable high, and on the next clock it pulls enable low. It then streams all 53 bytes without a break, with start-of-cell high on the first byte only. After each cell the block treats that PHY as busy until a fresh poll reports it available again.

Top module: `utx_master`

## Requirements
- R1: During and after reset, `tx_addr` is 5'h1F, `txen_n` is 1, `tx_soc` is 0 and `src_ready` is 0.
- R2: While idle, the block drives one enabled slot address per clock with `txen_n` high. It visits the enabled slots in round-robin order of slot index and skips disabled ones.
- R3: `tx_addr` is 5'h1F whenever nothing is polled: when no slot is enabled, and on every cycle with `txen_n` low.
- R4: The `tx_clav` level seen in the clock that follows an address cycle is taken as the status of the PHY at that address. A value seen in any other clock is not credited to that PHY.
- R5: Selection shows the target slot's address with `txen_n` high for exactly one clock. `txen_n` goes low on the next clock.
- R6: `txen_n` stays low for exactly 53 consecutive clocks. `tx_soc` is high on the first of them only. `tx_data` carries the source bytes in the order they were accepted.
- R7: A cell is started only when the most recent poll of its tagged slot returned 1. Until then `src_ready` stays low and `txen_n` stays high.
- R8: Once a cell to a PHY has been sent, that PHY is not selected again until a new poll returns 1.
- R9: A cell tagged with a disabled slot is never sent, and the address of a disabled slot is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bus clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_addr | input | 20 | Four 5-bit PHY addresses; slot i is bits [5i+4:5i] |
| slot_en | input | 4 | Per-slot enable; bit i enables slot i |
| src_valid | input | 1 | Source holds a cell; must stay high for all 53 bytes |
| src_dest | input | 2 | Slot index the pending cell is destined for |
| src_data | input | 8 | Current source byte |
| src_ready | output | 1 | Byte on `src_data` is taken at the next rising edge |
| txen_n | output | 1 | Active-low transmit enable |
| tx_soc | output | 1 | Start-of-cell flag, high with the first byte |
| tx_data | output | 8 | Transmit data lane |
| tx_addr | output | 5 | PHY address for polling and selection |
| tx_clav | input | 1 | Cell-available answer from the polled PHY |

## Verification
The bench models the PHYs with a register that answers the current address one clock later. It runs the main function against several PHY readiness patterns. When alternating polled PHYs disagree (one ready, one not), a status sampled one clock early or late credits the wrong slot and shows up as a wrong selection. A PHY that becomes ready only after the cell has waited shows that `src_ready` stalls and then releases. Clearing a PHY's readiness right after it receives a cell separates a design that re-polls from one that reuses stale status. A ready PHY whose slot is disabled checks that disabled entries are neither polled nor served.

// File: rtl/utx_master.sv
module utx_master #(
  parameter int NS = 4,
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int CELL_BYTES = 53,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS*AW-1:0] slot_addr,
  input  logic [NS-1:0]    slot_en,
  input  logic             src_valid,
  input  logic [SW-1:0]    src_dest,
  input  logic [DW-1:0]    src_data,
  output logic             src_ready,
  output logic             txen_n,
  output logic             tx_soc,
  output logic [DW-1:0]    tx_data,
  output logic [AW-1:0]    tx_addr,
  input  logic             tx_clav
);
  localparam logic [AW-1:0] NULL_ADDR = '1;
  localparam logic [CW-1:0] LAST = CW'(CELL_BYTES - 1);

  typedef enum logic [1:0] {S_POLL, S_SEL, S_XFER} st_t;
  st_t st;

  logic [SW-1:0] rr, nxt, sel, p0_slot, p1_slot;
  logic          p0_v, p1_v, any_en, go;
  logic [NS-1:0] avail;
  logic [CW-1:0] cnt;

  assign any_en = |slot_en;
  assign go = (st == S_POLL) && src_valid && slot_en[src_dest] && avail[src_dest];
  assign src_ready = (st == S_SEL) || (st == S_XFER && cnt != LAST);

  always_comb begin
    logic found;
    found = 1'b0;
    nxt = rr;
    for (int i = 1; i <= NS; i++) begin
      if (!found && slot_en[(int'(rr) + i) % NS]) begin
        nxt = SW'((int'(rr) + i) % NS);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_POLL;
      rr <= SW'(NS - 1);
      sel <= '0;
      p0_slot <= '0;
      p1_slot <= '0;
      p0_v <= 1'b0;
      p1_v <= 1'b0;
      avail <= '0;
      cnt <= '0;
      txen_n <= 1'b1;
      tx_soc <= 1'b0;
      tx_data <= '0;
      tx_addr <= NULL_ADDR;
    end else begin
      p1_slot <= p0_slot;
      p1_v <= p0_v;
      p0_v <= 1'b0;
      if (p1_v) avail[p1_slot] <= tx_clav;
      case (st)
        S_POLL: begin
          if (go) begin
            st <= S_SEL;
            sel <= src_dest;
            tx_addr <= slot_addr[src_dest*AW +: AW];
          end else if (any_en) begin
            rr <= nxt;
            p0_slot <= nxt;
            p0_v <= 1'b1;
            tx_addr <= slot_addr[nxt*AW +: AW];
          end else begin
            tx_addr <= NULL_ADDR;
          end
        end
        S_SEL: begin
          st <= S_XFER;
          cnt <= '0;
          txen_n <= 1'b0;
          tx_soc <= 1'b1;
          tx_data <= src_data;
          tx_addr <= NULL_ADDR;
        end
        default: begin
          tx_soc <= 1'b0;
          if (cnt == LAST) begin
            st <= S_POLL;
            txen_n <= 1'b1;
            avail[sel] <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
            tx_data <= src_data;
          end
        end
      endcase
    end
  end
endmodule

module utx_master_chk #(
  parameter int AW = 5,
  parameter int CELL_BYTES = 53
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txen_n,
  input logic          tx_soc,
  input logic [AW-1:0] tx_addr,
  input logic          src_ready
);
  int run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else if (!txen_n) run <= run + 1;
    else run <= 0;
  end

  a_r6_soc_in_cell: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |-> !txen_n);
  a_r6_soc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |=> !tx_soc);
  a_r5_start_has_soc: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txen_n) |-> tx_soc);
  a_r5_select_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txen_n) |-> $past(tx_addr) != '1);
  a_r3_null_in_cell: assert property (@(posedge clk) disable iff (!rst_n)
    !txen_n |-> tx_addr == '1);
  a_r6_cell_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen_n) |-> run == CELL_BYTES);
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    run <= CELL_BYTES);
  a_r7_ready_in_cell: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && txen_n) |=> !txen_n);
endmodule

bind utx_master utx_master_chk #(.AW(AW), .CELL_BYTES(CELL_BYTES)) u_chk (.*);

// File: tb/sim_utx_master.sv
module sim_utx_master;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [19:0] slot_addr;
  logic [3:0] slot_en = 0;
  logic src_valid = 0;
  logic [1:0] src_dest = 0;
  logic [7:0] src_data = 0;
  logic src_ready, txen_n, tx_soc, tx_clav;
  logic [7:0] tx_data;
  logic [4:0] tx_addr;
  logic [31:0] phy_rdy = 0;
  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) tx_clav <= phy_rdy[tx_addr];

  utx_master u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_addr == 5'h1F, "R1 addr", tx_addr, 31);
    chk(txen_n == 1 && tx_soc == 0, "R1 enable/soc", {txen_n, tx_soc}, 2);
    chk(src_ready == 0, "R1 ready", src_ready, 0);
  endtask

  task automatic t_null();
    int bad = 0;
    slot_en = 0;
    repeat (3) @(negedge clk);
    repeat (6) begin @(negedge clk); if (tx_addr != 5'h1F || !txen_n) bad++; end
    chk(bad == 0, "R3 idle null address", bad, 0);
  endtask

  task automatic t_poll();
    logic [4:0] a [4];
    int bad = 0;
    slot_en = 4'b0101; phy_rdy = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); a[i] = tx_addr;
      if (!txen_n || (a[i] != 5'd3 && a[i] != 5'd9)) bad++;
      if (i > 0 && a[i] == a[i-1]) bad++;
    end
    chk(bad == 0, "R2 round robin over slots 0 and 2", bad, 0);
  endtask

  task automatic no_go(input logic [1:0] d, input int n, input logic [4:0] forbid, input string req);
    int bad = 0;
    src_valid = 1; src_dest = d;
    repeat (n) begin
      @(negedge clk);
      if (!txen_n || src_ready || tx_addr == forbid) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic send_cell(input logic [1:0] d, input logic [7:0] base, input logic [4:0] exp_addr, input string req);
    int idx = 0, k = 0, phase = 0, t = 0, soc_bad = 0, dat_bad = 0, adr_bad = 0, len = 0;
    bit prev_rdy = 0, prev_en = 1, sel_ok = 0;
    logic [4:0] prev_addr = 5'h1F;
    src_valid = 1; src_dest = d; src_data = base;
    while (phase != 2 && t < 400) begin
      @(negedge clk); t++;
      if (prev_rdy) idx++;
      if (idx >= 53) src_valid = 0;
      src_data = 8'(base + idx);
      prev_rdy = src_ready;
      if (phase == 0 && !txen_n) begin
        sel_ok = prev_en && prev_addr == exp_addr;
        if (!sel_ok) $display("FAIL %s select: actual addr %0d en %0d expected addr %0d en 1", req, prev_addr, prev_en, exp_addr);
        phase = 1;
      end
      if (phase == 1) begin
        if (txen_n) begin len = k; phase = 2; end
        else begin
          if (tx_soc != (k == 0)) soc_bad++;
          if (tx_data != 8'(base + k)) dat_bad++;
          if (tx_addr != 5'h1F) adr_bad++;
          k++;
        end
      end
      prev_en = txen_n; prev_addr = tx_addr;
    end
    src_valid = 0;
    n_chk++; if (!sel_ok) n_bad++;
    chk(len == 53, {req, " R6 enable length"}, len, 53);
    chk(soc_bad == 0, {req, " R6 soc first only"}, soc_bad, 0);
    chk(dat_bad == 0, {req, " R6 data order"}, dat_bad, 0);
    chk(adr_bad == 0, {req, " R3 null during cell"}, adr_bad, 0);
    chk(idx == 53, {req, " R6 bytes accepted"}, idx, 53);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    slot_addr = {5'd12, 5'd9, 5'd6, 5'd3};
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_null();
    t_poll();
    // R4: slot0 ready, slot1 not, polled alternately
    slot_en = 4'b0011; phy_rdy = 0; phy_rdy[3] = 1;
    no_go(2'd1, 30, 5'h1E, "R4 unready slot1 not credited");
    send_cell(2'd0, 8'h10, 5'd3, "R4 ready slot0 served");
    // R7: waits, then goes once ready
    no_go(2'd1, 20, 5'h1E, "R7 stall until available");
    phy_rdy[6] = 1;
    send_cell(2'd1, 8'hF0, 5'd6, "R7 released");
    // R8: stale status not reused
    phy_rdy[6] = 0;
    no_go(2'd1, 30, 5'h1E, "R8 re-poll before next cell");
    phy_rdy[6] = 1;
    send_cell(2'd1, 8'h40, 5'd6, "R8 after re-poll");
    // R9: disabled slot
    slot_en = 4'b0001;
    no_go(2'd1, 30, 5'd6, "R9 disabled slot ignored");
    slot_en = 4'b0011;
    send_cell(2'd1, 8'h80, 5'd6, "R9 re-enabled");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule